// File: doc/BRIEF.md
# Peak-Relative Capture Start Detector

This block watches a stream of unsigned 8-bit samples from a demodulated tag response. The samples rest around mid-scale, 128. It decides when a capture buffer starts filling. After an arm pulse it can first write a constant fill value through the whole capture window. It then hunts for the response. Samples that never rise above a high threshold are thrown away.

Once the signal has gone high, the block tracks the highest sample seen. Capture begins on the first sample that lies more than a set tolerance below that peak. The peak value is written first, then the sample that caused the trigger, then every later valid sample with no further checks. Writing stops when the capture window is full, and a one-cycle done pulse marks that point.

The storage itself and all decoding after capture sit outside this block. The block drives a write strobe, data and address toward an external memory.

Top module: `peak_capture_start`

## Requirements
- R1: After an arm pulse (with the prefill option on), the block writes the value 0x80 to addresses 0 to CAP-1, one per cycle, in consecutive cycles. CAP is the smaller of MAX_LEN and BUF_DEPTH. Samples that arrive during this fill are ignored, and done stays low.
- R2: While hunting, samples at or below the threshold (default 168) cause no write until a sample above the threshold has arrived.
- R3: Before capture starts, every sample above the threshold that exceeds the tracked peak replaces it. The tracked peak is 0 after arm.
- R4: Capture starts on a valid sample that is strictly more than TOL (default 5) below the tracked peak, compared with signed arithmetic. A sample exactly TOL below the peak does not start capture.
- R5: On the start condition, the tracked peak is written to address 0 and the triggering sample to address 1.
- R6: Once capture has started, every valid sample is written in arrival order to the next address, with no threshold test. Cycles without a valid sample produce no write.
- R7: Capture writes exactly CAP entries. Samples arriving after the last one cause no write.
- R8: The done output is a one-cycle pulse that coincides with the write to address CAP-1 and appears at no other time.
- R9: An arm pulse at any time abandons the current run and clears the tracked peak, the high-seen flag and the started flag.
- R10: After reset, no write occurs and done is low until an arm pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start a new run (prefill, then hunt) |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Unsigned sample, mid-scale 128 |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_data_o | output | SMP_W | Buffer write data |
| wr_addr_o | output | AW | Buffer write address, AW = clog2(CAP) |
| done_o | output | 1 | One-cycle pulse with the last capture write |

## Verification
Directed streams are used for the threshold and tolerance boundaries:
- A stream that stays exactly at the threshold, which must never trigger.
- A peak followed by a sample exactly TOL below it and then one more below it, which separates the strict and non-strict compare.
- High noise during the fill, which would raise the peak if it were not ignored.
- A restart after a partial capture, where a peak left over from the previous run would trigger too early.

A long stream that overruns the window shows where the cap and the done pulse fall. Seeded random streams with gaps in the valid strobe, drawn around the threshold, mix peak updates, late triggers and stalls during capture. Each run is compared write by write with a bench model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_HUNT = 2'd2,
      ST_CAPT = 2'd3
   } pcs_state_e;

   function automatic int pcs_min(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/pcs_peak_tracker.sv
module pcs_peak_tracker #(
   parameter int SMP_W  = 8,
   parameter int THRESH = 168,
   parameter int TOL    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [SMP_W-1:0] smp_i,
   output logic [SMP_W-1:0] peak_o,
   output logic             fire_o
);
   localparam int DW = SMP_W + 2;

   logic [SMP_W-1:0] peak_q;
   logic             high_q;
   logic signed [DW-1:0] smp_s;
   logic signed [DW-1:0] floor_s;
   logic             above;
   logic             upd;

   initial begin
      if (THRESH < 0 || THRESH >= (1 << SMP_W))
         $error("pcs_peak_tracker: THRESH outside sample range");
      if (TOL < 0 || TOL >= (1 << SMP_W))
         $error("pcs_peak_tracker: TOL outside sample range");
   end

   always_comb begin
      smp_s   = $signed({2'b00, smp_i});
      floor_s = $signed({2'b00, peak_q}) - $signed(DW'(TOL));
      above   = smp_i > SMP_W'(THRESH);
      upd     = en_i && above && (smp_i > peak_q);
      fire_o  = en_i && high_q && (smp_s < floor_s);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak_q <= '0;
         high_q <= 1'b0;
      end else if (clr_i) begin
         peak_q <= '0;
         high_q <= 1'b0;
      end else if (upd) begin
         peak_q <= smp_i;
         high_q <= 1'b1;
      end
   end

   assign peak_o = peak_q;

   AST_PEAK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (high_q && !clr_i) |=> (peak_q >= $past(peak_q))); // R3

endmodule

// File: rtl/pcs_addr_ctr.sv
module pcs_addr_ctr #(
   parameter int CAP = 24,
   parameter int AW  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [AW-1:0] cnt_o,
   output logic          last_o
);
   localparam logic [AW-1:0] LAST = AW'(CAP - 1);

   logic [AW-1:0] cnt_q;

   initial begin
      if (CAP < 2) $error("pcs_addr_ctr: CAP must be at least 2");
      if ((1 << AW) < CAP) $error("pcs_addr_ctr: AW too narrow for CAP");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (clr_i)               cnt_q <= '0;
      else if (inc_i && cnt_q != LAST) cnt_q <= cnt_q + AW'(1);
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/peak_capture_start.sv
module peak_capture_start
   import pcs_pkg::*;
#(
   parameter int SMP_W      = 8,
   parameter int THRESH     = 168,
   parameter int TOL        = 5,
   parameter int MAX_LEN    = 12000,
   parameter int BUF_DEPTH  = 16384,
   parameter bit PREFILL_EN = 1'b1,
   parameter int FILL_VAL   = 128,
   localparam int CAP       = pcs_min(MAX_LEN, BUF_DEPTH),
   localparam int AW        = (CAP > 1) ? $clog2(CAP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             smp_valid_i,
   input  logic [SMP_W-1:0] smp_i,
   output logic             wr_en_o,
   output logic [SMP_W-1:0] wr_data_o,
   output logic [AW-1:0]    wr_addr_o,
   output logic             done_o
);
   localparam logic [AW-1:0] LAST_ADDR = AW'(CAP - 1);

   pcs_state_e       state_q;
   pcs_state_e       arm_target;
   logic [SMP_W-1:0] pend_q;
   logic             pend_v_q;
   logic             trk_en;
   logic             fire;
   logic [SMP_W-1:0] peak;
   logic [AW-1:0]    cnt;
   logic             cnt_last;
   logic             cnt_clr;
   logic             cnt_inc;

   initial begin
      if (SMP_W < 2)  $error("peak_capture_start: SMP_W too small");
      if (CAP < 2)    $error("peak_capture_start: capture window must hold two entries");
      if (FILL_VAL < 0 || FILL_VAL >= (1 << SMP_W))
         $error("peak_capture_start: FILL_VAL outside sample range");
   end

   generate
      if (PREFILL_EN) begin : g_prefill
         assign arm_target = ST_FILL;
      end else begin : g_no_prefill
         assign arm_target = ST_HUNT;
      end
   endgenerate

   assign trk_en  = smp_valid_i && !arm_i && (state_q == ST_HUNT);
   assign cnt_clr = arm_i || ((state_q == ST_FILL) && cnt_last);
   assign cnt_inc = !arm_i && (((state_q == ST_FILL)) ||
                               ((state_q == ST_HUNT) && fire) ||
                               ((state_q == ST_CAPT) && pend_v_q));

   pcs_peak_tracker #(
      .SMP_W  (SMP_W),
      .THRESH (THRESH),
      .TOL    (TOL)
   ) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (arm_i),
      .en_i   (trk_en),
      .smp_i  (smp_i),
      .peak_o (peak),
      .fire_o (fire)
   );

   pcs_addr_ctr #(
      .CAP (CAP),
      .AW  (AW)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr),
      .inc_i  (cnt_inc),
      .cnt_o  (cnt),
      .last_o (cnt_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pend_q    <= '0;
         pend_v_q  <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_data_o <= '0;
         wr_addr_o <= '0;
         done_o    <= 1'b0;
      end else begin
         wr_en_o <= 1'b0;
         done_o  <= 1'b0;
         if (arm_i) begin
            state_q  <= arm_target;
            pend_v_q <= 1'b0;
         end else begin
            case (state_q)
               ST_FILL: begin
                  wr_en_o   <= 1'b1;
                  wr_data_o <= SMP_W'(FILL_VAL);
                  wr_addr_o <= cnt;
                  if (cnt_last) state_q <= ST_HUNT;
               end
               ST_HUNT: begin
                  if (fire) begin
                     wr_en_o   <= 1'b1;
                     wr_data_o <= peak;
                     wr_addr_o <= cnt;
                     pend_q    <= smp_i;
                     pend_v_q  <= 1'b1;
                     state_q   <= ST_CAPT;
                  end
               end
               ST_CAPT: begin
                  pend_q   <= smp_i;
                  pend_v_q <= smp_valid_i;
                  if (pend_v_q) begin
                     wr_en_o   <= 1'b1;
                     wr_data_o <= pend_q;
                     wr_addr_o <= cnt;
                     if (cnt_last) begin
                        done_o   <= 1'b1;
                        pend_v_q <= 1'b0;
                        state_q  <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  pend_v_q <= 1'b0;
               end
            endcase
         end
      end
   end

   AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_addr_o <= LAST_ADDR)); // R7

   AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (wr_en_o && wr_addr_o == LAST_ADDR)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8

   AST_FIRST_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && state_q == ST_CAPT && wr_addr_o == '0)
         |-> (wr_data_o > SMP_W'(THRESH))); // R5

endmodule

// File: tb/peak_capture_start_bench.sv
`timescale 1ns/100ps
module peak_capture_start_bench;
   localparam int SMP_W  = 8;
   localparam int THRESH = 168;
   localparam int TOL    = 5;
   localparam int CAP    = 24;
   localparam int AW     = 5;
   localparam int LOGN   = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0;
   logic vld = 1'b0;
   logic [SMP_W-1:0] smp = '0;
   logic wr_en;
   logic [SMP_W-1:0] wr_data;
   logic [AW-1:0] wr_addr;
   logic done;

   int checks = 0;
   int failures = 0;

   int stim_s [LOGN];
   bit stim_v [LOGN];
   int act_d [LOGN];
   int act_a [LOGN];
   bit act_dn[LOGN];
   int act_n = 0;
   int exp_d [LOGN];
   int exp_a [LOGN];
   bit exp_dn[LOGN];
   int exp_n;

   always #2.5 clk = ~clk;

   peak_capture_start #(
      .SMP_W(SMP_W), .THRESH(THRESH), .TOL(TOL),
      .MAX_LEN(40), .BUF_DEPTH(CAP), .PREFILL_EN(1'b1), .FILL_VAL(128)
   ) u_peak_capture_start (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .smp_valid_i(vld), .smp_i(smp),
      .wr_en_o(wr_en), .wr_data_o(wr_data), .wr_addr_o(wr_addr), .done_o(done)
   );

   always @(negedge clk) begin
      if (rst_n && (wr_en || done)) begin
         if (act_n < LOGN) begin
            act_d[act_n]  = int'(wr_data);
            act_a[act_n]  = int'(wr_addr);
            act_dn[act_n] = done;
         end
         act_n = act_n + 1;
      end
   end

   task automatic check(input string tag, input bit ok, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Model: the fill comes first, then peak-relative triggering and a capped capture.
   task automatic model(input int n);
      int peak = 0;
      bit high = 0;
      bit started = 0;
      int cnt = 0;
      exp_n = 0;
      for (int i = 0; i < CAP; i++) begin
         exp_d[exp_n] = 128; exp_a[exp_n] = i; exp_dn[exp_n] = 0; exp_n++;
      end
      for (int i = 0; i < n; i++) begin
         if (stim_v[i]) begin
            if (!started) begin
               if (high && (stim_s[i] < peak - TOL)) begin
                  started = 1;
                  exp_d[exp_n] = peak; exp_a[exp_n] = cnt; exp_dn[exp_n] = 0; exp_n++; cnt++;
                  exp_d[exp_n] = stim_s[i]; exp_a[exp_n] = cnt; exp_dn[exp_n] = 0; exp_n++; cnt++;
               end else if (stim_s[i] > THRESH && stim_s[i] > peak) begin
                  peak = stim_s[i];
                  high = 1;
               end
            end else if (cnt < CAP) begin
               exp_d[exp_n] = stim_s[i]; exp_a[exp_n] = cnt; exp_dn[exp_n] = (cnt == CAP-1);
               exp_n++; cnt++;
            end
         end
      end
   endtask

   task automatic run_case(input string tag, input int n, input bit fill_noise);
      act_n = 0;
      @(negedge clk); arm = 1'b1; vld = 1'b0;
      @(negedge clk); arm = 1'b0;
      if (fill_noise) begin vld = 1'b1; smp = 8'd250; end
      repeat (CAP) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         smp = stim_s[i][SMP_W-1:0];
         vld = stim_v[i];
         @(negedge clk);
      end
      vld = 1'b0;
      repeat (4) @(negedge clk);
      model(n);
      check({tag, " write count"}, act_n == exp_n, act_n, exp_n);
      for (int i = 0; i < exp_n && i < act_n; i++) begin
         check({tag, " data"}, act_d[i] == exp_d[i], act_d[i], exp_d[i]);
         check({tag, " addr"}, act_a[i] == exp_a[i], act_a[i], exp_a[i]);
         check({tag, " done R8"}, act_dn[i] == exp_dn[i], int'(act_dn[i]), int'(exp_dn[i]));
      end
   endtask

   task automatic put(input int i, input int s, input bit v);
      stim_s[i] = s; stim_v[i] = v;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: quiet after reset
      repeat (3) @(negedge clk);
      check("R10 reset write", wr_en == 1'b0 && act_n == 0, int'(wr_en), 0);
      check("R10 reset done", done == 1'b0, int'(done), 0);

      // R1 R2: stays at the threshold, only the fill is written
      for (int i = 0; i < 10; i++) put(i, (i % 2) ? 168 : 100, 1'b1);
      run_case("R1 R2 at-threshold", 10, 1'b0);

      // R3 R4 R5 R6: peak 210, 205 is exactly TOL below (no start), 204 starts, gaps after
      put(0, 160, 1); put(1, 170, 1); put(2, 200, 1); put(3, 210, 1); put(4, 190, 0);
      put(5, 205, 1); put(6, 204, 1); put(7, 50, 1); put(8, 0, 0); put(9, 60, 1);
      put(10, 220, 1); put(11, 0, 0); put(12, 0, 0); put(13, 70, 1);
      run_case("R3 R4 R5 R6 boundary", 14, 1'b0);

      // R1: noise during the fill must not raise the peak
      put(0, 180, 1); put(1, 176, 1); put(2, 174, 1); put(3, 90, 1);
      run_case("R1 fill-ignore", 4, 1'b1);

      // R9: partial run with peak 200, then restart with peak 180
      put(0, 200, 1); put(1, 150, 1); put(2, 151, 1);
      run_case("R9 first run", 3, 1'b0);
      put(0, 180, 1); put(1, 176, 1); put(2, 174, 1); put(3, 10, 1);
      run_case("R9 restart", 4, 1'b0);

      // R7 R8: overrun the window
      put(0, 180, 1); put(1, 200, 1); put(2, 150, 1);
      for (int i = 3; i < 50; i++) put(i, i * 3, (i % 7) != 0);
      run_case("R7 R8 overrun", 50, 1'b0);

      // seeded random streams around the threshold
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < 60; i++)
            put(i, 120 + int'($urandom % 111), ($urandom % 4) != 0);
         run_case("R4 R6 R7 random", 60, r[0]);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule